// File: doc/BRIEF.md
# Memory Throughput Probe (AXI4 Burst Traffic Generator)

This block is an AXI4 master that loads a wide memory port as hard as the protocol permits, so that the port's real throughput can be measured. A single start pulse runs two back-to-back phases over one region of memory. The first phase writes the whole region with full-length incrementing bursts. The second phase reads the same region back. Up to sixteen bursts are kept in flight in each phase. Every burst is exactly 4 KiB long, which keeps it inside one 4 KiB page.

The block keeps a free-running cycle count for each phase. It also keeps sticky error flags for non-OKAY write and read responses, a flag for misplaced read-last markers, and a count of read beats whose data differs from the pattern that was written. All results are plain output registers. Throughput is computed outside the block from the cycle counts and the region size, so no clock frequency is assumed inside the block. For a 256 MiB region, set `cfg_bursts` to 65536. `cfg_bursts` must be at least 1.

Top module: `axi_bw_probe`

## Requirements
- R1: Every write address request carries length 127 (128 beats), size code 5 (32-byte beats) and burst type 2'b01 (incrementing). The k-th request, counting k from 0 to `cfg_bursts`-1 in issue order, has address `cfg_base` + k*4096.
- R2: Every write burst has 128 beats, and `wlast` is high on the 128th beat only. All strobes are high. Each beat is written to byte address A, and its 32-bit lane i (bits 32i+31:32i, i = 0..7) holds the low 32 bits of A + i.
- R3: In each phase, at most 16 bursts are in flight at once. For writes, in flight means address handshakes minus write responses. For reads, it means address handshakes minus read bursts whose 128th beat has returned. New requests stall at 16 and resume as bursts retire.
- R4: No read address is presented until every write response of the run has been received. Read requests then follow the same address sequence as R1, with the same length, size and type.
- R5: Once a VALID is raised, it stays high and its payload stays unchanged until READY is seen. `bready` and `rready` are high at all times.
- R6: `wr_cycles` equals the number of clock cycles from the first cycle with `awvalid` high through the cycle of the last write-response handshake, both counted.
- R7: `rd_cycles` equals the number of clock cycles from the first cycle with `arvalid` high through the cycle of the last read-data handshake, both counted.
- R8: A write response other than OKAY (2'b00) sets `wr_err`, which stays set. The run still completes.
- R9: A read response other than OKAY sets `rd_err`, which stays set. The run still completes.
- R10: `mismatch_cnt` counts the read beats whose data differs from the R2 pattern for that beat's address.
- R11: If `rlast` is high on any beat other than the 128th of a burst, or low on the 128th, `rlast_err` is set and stays set.
- R12: `done` rises after the read phase ends and holds until the next accepted start. An accepted start clears `done`, both cycle counts, all flags and `mismatch_cnt`. A start pulse while a run is in progress is ignored.
- R13: Out of reset, `done`, both cycle counts, all flags and `mismatch_cnt` are zero, and `awvalid`, `wvalid` and `arvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a run |
| cfg_base | input | 32 | Region base address, 4 KiB aligned |
| cfg_bursts | input | 17 | Region size in 4 KiB bursts |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | 32 | Write burst address |
| awlen | output | 8 | Write burst length minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 256 | Write data |
| wstrb | output | 32 | Write byte strobes |
| wlast | output | 1 | Last write beat of burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bresp | input | 2 | Write response code |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | 32 | Read burst address |
| arlen | output | 8 | Read burst length minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | 256 | Read data |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Last read beat marker |
| done | output | 1 | Both phases finished |
| wr_cycles | output | 32 | Write phase cycle count |
| rd_cycles | output | 32 | Read phase cycle count |
| wr_err | output | 1 | Sticky write response error |
| rd_err | output | 1 | Sticky read response error |
| rlast_err | output | 1 | Sticky misplaced read-last error |
| mismatch_cnt | output | 32 | Read data miscompare count |

## Verification
The assertions check these rules on every cycle: VALID and payload are held while READY is low, each write address is aligned to its burst length and page, `wlast` falls on the correct beat, in-flight counts in both phases never exceed sixteen, no read address appears while write responses are pending, and `done` holds until a start. Other behaviour can only be shown by the bench's scenarios. These are the exact address order, the data pattern, the agreement of both cycle counts with an independent count of bus activity, the stall that actually reaches sixteen under slow responses, the sticky flags and the miscompare count under injected faults, and a start pulse that is ignored while a run is in progress.

// File: rtl/axi_bw_pkg.sv
package axi_bw_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_WRITE = 2'd1,
      PH_READ  = 2'd2,
      PH_DONE  = 2'd3
   } phase_e;

   localparam logic [1:0] RESP_OKAY  = 2'b00;
   localparam logic [1:0] BURST_INCR = 2'b01;
   localparam int unsigned LANE_W    = 32;
endpackage

// File: rtl/bw_pattern.sv
module bw_pattern #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 256
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);
   import axi_bw_pkg::*;
   localparam int unsigned LANES = DATA_W / LANE_W;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [ADDR_W-1:0] sum;
      assign sum = addr + ADDR_W'(i);
      assign data[i*LANE_W +: LANE_W] = sum[LANE_W-1:0];
   end
endmodule

// File: rtl/bw_cycle_timer.sv
module bw_cycle_timer #(
   parameter int unsigned CYC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   output logic [CYC_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)      count <= '0;
      else if (clr)    count <= '0;
      else if (run)    count <= count + CYC_W'(1);
   end
endmodule

// File: rtl/bw_wr_engine.sv
module bw_wr_engine #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 256,
   parameter int unsigned BURST_W = 17,
   parameter int unsigned BEATS   = 128,
   parameter int unsigned MAX_OUT = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic [ADDR_W-1:0]   base,
   input  logic [BURST_W-1:0]  bursts,
   output logic                awvalid,
   input  logic                awready,
   output logic [ADDR_W-1:0]   awaddr,
   output logic [7:0]          awlen,
   output logic [2:0]          awsize,
   output logic [1:0]          awburst,
   output logic                wvalid,
   input  logic                wready,
   output logic [DATA_W-1:0]   wdata,
   output logic [DATA_W/8-1:0] wstrb,
   output logic                wlast,
   input  logic                bvalid,
   output logic                bready,
   input  logic [1:0]          bresp,
   output logic                busy,
   output logic                err,
   output logic                fin
);
   import axi_bw_pkg::*;
   localparam int unsigned BYTES       = DATA_W / 8;
   localparam int unsigned SIZE_CODE   = $clog2(BYTES);
   localparam int unsigned BURST_SHIFT = $clog2(BEATS * BYTES);
   localparam int unsigned BEAT_W      = $clog2(BEATS);
   localparam logic [BURST_W-1:0] OUT_LIM = BURST_W'(MAX_OUT);

   logic               active;
   logic [BURST_W-1:0] aw_cnt, w_burst, b_cnt;
   logic [BEAT_W-1:0]  w_beat;
   logic [ADDR_W-1:0]  beat_addr;
   logic               b_last;

   assign awvalid   = active && (aw_cnt != bursts) && ((aw_cnt - b_cnt) < OUT_LIM);
   assign awaddr    = base + (ADDR_W'(aw_cnt) << BURST_SHIFT);
   assign awlen     = 8'(BEATS - 1);
   assign awsize    = 3'(SIZE_CODE);
   assign awburst   = BURST_INCR;

   assign wvalid    = active && (w_burst != aw_cnt);
   assign beat_addr = base + (ADDR_W'(w_burst) << BURST_SHIFT) + (ADDR_W'(w_beat) << SIZE_CODE);
   assign wstrb     = '1;
   assign wlast     = (w_beat == BEAT_W'(BEATS - 1));

   bw_pattern #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pat (
      .addr (beat_addr),
      .data (wdata)
   );

   assign bready = 1'b1;
   assign b_last = active && bvalid && (b_cnt == bursts - BURST_W'(1));
   assign fin    = b_last;
   assign busy   = active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         aw_cnt  <= '0;
         w_burst <= '0;
         w_beat  <= '0;
         b_cnt   <= '0;
         err     <= 1'b0;
      end else if (go) begin
         active  <= 1'b1;
         aw_cnt  <= '0;
         w_burst <= '0;
         w_beat  <= '0;
         b_cnt   <= '0;
         err     <= 1'b0;
      end else begin
         if (awvalid && awready) aw_cnt <= aw_cnt + BURST_W'(1);
         if (wvalid && wready) begin
            if (wlast) begin
               w_beat  <= '0;
               w_burst <= w_burst + BURST_W'(1);
            end else begin
               w_beat  <= w_beat + BEAT_W'(1);
            end
         end
         if (active && bvalid) begin
            b_cnt <= b_cnt + BURST_W'(1);
            if (bresp != RESP_OKAY) err <= 1'b1;
         end
         if (b_last) active <= 1'b0;
      end
   end
endmodule

// File: rtl/bw_rd_engine.sv
module bw_rd_engine #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 256,
   parameter int unsigned BURST_W    = 17,
   parameter int unsigned BEATS      = 128,
   parameter int unsigned MAX_OUT    = 16,
   parameter int unsigned CNT_W      = 32,
   parameter bit          CHECK_DATA = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               go,
   input  logic [ADDR_W-1:0]  base,
   input  logic [BURST_W-1:0] bursts,
   output logic               arvalid,
   input  logic               arready,
   output logic [ADDR_W-1:0]  araddr,
   output logic [7:0]         arlen,
   output logic [2:0]         arsize,
   output logic [1:0]         arburst,
   input  logic               rvalid,
   output logic               rready,
   input  logic [DATA_W-1:0]  rdata,
   input  logic [1:0]         rresp,
   input  logic               rlast,
   output logic               busy,
   output logic               err,
   output logic               last_err,
   output logic [CNT_W-1:0]   mismatches,
   output logic               fin
);
   import axi_bw_pkg::*;
   localparam int unsigned BYTES       = DATA_W / 8;
   localparam int unsigned SIZE_CODE   = $clog2(BYTES);
   localparam int unsigned BURST_SHIFT = $clog2(BEATS * BYTES);
   localparam int unsigned BEAT_W      = $clog2(BEATS);
   localparam logic [BURST_W-1:0] OUT_LIM = BURST_W'(MAX_OUT);

   logic               active;
   logic [BURST_W-1:0] ar_cnt, r_burst;
   logic [BEAT_W-1:0]  r_beat;
   logic               final_beat;
   logic               beat_bad;
   logic               take;

   assign arvalid = active && (ar_cnt != bursts) && ((ar_cnt - r_burst) < OUT_LIM);
   assign araddr  = base + (ADDR_W'(ar_cnt) << BURST_SHIFT);
   assign arlen   = 8'(BEATS - 1);
   assign arsize  = 3'(SIZE_CODE);
   assign arburst = BURST_INCR;
   assign rready  = 1'b1;

   assign take       = active && rvalid;
   assign final_beat = (r_beat == BEAT_W'(BEATS - 1));
   assign fin        = take && final_beat && (r_burst == bursts - BURST_W'(1));
   assign busy       = active;

   if (CHECK_DATA) begin : g_cmp
      logic [ADDR_W-1:0] exp_addr;
      logic [DATA_W-1:0] exp_data;
      assign exp_addr = base + (ADDR_W'(r_burst) << BURST_SHIFT) + (ADDR_W'(r_beat) << SIZE_CODE);
      bw_pattern #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pat (
         .addr (exp_addr),
         .data (exp_data)
      );
      assign beat_bad = (rdata != exp_data);
   end else begin : g_nocmp
      assign beat_bad = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         active     <= 1'b0;
         ar_cnt     <= '0;
         r_burst    <= '0;
         r_beat     <= '0;
         err        <= 1'b0;
         last_err   <= 1'b0;
         mismatches <= '0;
      end else if (go) begin
         active  <= 1'b1;
         ar_cnt  <= '0;
         r_burst <= '0;
         r_beat  <= '0;
      end else begin
         if (arvalid && arready) ar_cnt <= ar_cnt + BURST_W'(1);
         if (take) begin
            if (final_beat) begin
               r_beat  <= '0;
               r_burst <= r_burst + BURST_W'(1);
            end else begin
               r_beat  <= r_beat + BEAT_W'(1);
            end
            if (rresp != RESP_OKAY)   err        <= 1'b1;
            if (rlast != final_beat)  last_err   <= 1'b1;
            if (beat_bad)             mismatches <= mismatches + CNT_W'(1);
         end
         if (fin) active <= 1'b0;
      end
   end
endmodule

// File: rtl/axi_bw_probe.sv
module axi_bw_probe #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 256,
   parameter int unsigned BURST_W    = 17,
   parameter int unsigned BEATS      = 128,
   parameter int unsigned MAX_OUT    = 16,
   parameter int unsigned CYC_W      = 32,
   parameter int unsigned CNT_W      = 32,
   parameter bit          CHECK_DATA = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [ADDR_W-1:0]   cfg_base,
   input  logic [BURST_W-1:0]  cfg_bursts,
   output logic                awvalid,
   input  logic                awready,
   output logic [ADDR_W-1:0]   awaddr,
   output logic [7:0]          awlen,
   output logic [2:0]          awsize,
   output logic [1:0]          awburst,
   output logic                wvalid,
   input  logic                wready,
   output logic [DATA_W-1:0]   wdata,
   output logic [DATA_W/8-1:0] wstrb,
   output logic                wlast,
   input  logic                bvalid,
   output logic                bready,
   input  logic [1:0]          bresp,
   output logic                arvalid,
   input  logic                arready,
   output logic [ADDR_W-1:0]   araddr,
   output logic [7:0]          arlen,
   output logic [2:0]          arsize,
   output logic [1:0]          arburst,
   input  logic                rvalid,
   output logic                rready,
   input  logic [DATA_W-1:0]   rdata,
   input  logic [1:0]          rresp,
   input  logic                rlast,
   output logic                done,
   output logic [CYC_W-1:0]    wr_cycles,
   output logic [CYC_W-1:0]    rd_cycles,
   output logic                wr_err,
   output logic                rd_err,
   output logic                rlast_err,
   output logic [CNT_W-1:0]    mismatch_cnt
);
   import axi_bw_pkg::*;
   localparam int unsigned BURST_BYTES = BEATS * DATA_W / 8;

   initial begin
      if (DATA_W % LANE_W != 0) $error("DATA_W must be a multiple of 32");
      if (BURST_BYTES > 4096 || (BURST_BYTES & (BURST_BYTES - 1)) != 0)
         $error("burst must be a power of two no larger than 4 KiB");
      if (BEATS < 2 || BEATS > 256) $error("BEATS out of AXI4 range");
      if (MAX_OUT < 1 || MAX_OUT >= (1 << BURST_W)) $error("MAX_OUT out of range");
      if (ADDR_W < LANE_W) $error("ADDR_W must be at least 32");
   end

   phase_e state;
   logic   start_acc, rd_go;
   logic   wr_busy, wr_fin, rd_busy, rd_fin;

   assign start_acc = start && ((state == PH_IDLE) || (state == PH_DONE));
   assign rd_go     = (state == PH_WRITE) && wr_fin;
   assign done      = (state == PH_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n)                              state <= PH_IDLE;
      else if (start_acc)                      state <= PH_WRITE;
      else if (rd_go)                          state <= PH_READ;
      else if ((state == PH_READ) && rd_fin)   state <= PH_DONE;
   end

   bw_wr_engine #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_W(BURST_W),
      .BEATS(BEATS), .MAX_OUT(MAX_OUT)
   ) u_wr (
      .clk(clk), .rst_n(rst_n), .go(start_acc),
      .base(cfg_base), .bursts(cfg_bursts),
      .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
      .awlen(awlen), .awsize(awsize), .awburst(awburst),
      .wvalid(wvalid), .wready(wready), .wdata(wdata),
      .wstrb(wstrb), .wlast(wlast),
      .bvalid(bvalid), .bready(bready), .bresp(bresp),
      .busy(wr_busy), .err(wr_err), .fin(wr_fin)
   );

   bw_rd_engine #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_W(BURST_W),
      .BEATS(BEATS), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W),
      .CHECK_DATA(CHECK_DATA)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .clr(start_acc), .go(rd_go),
      .base(cfg_base), .bursts(cfg_bursts),
      .arvalid(arvalid), .arready(arready), .araddr(araddr),
      .arlen(arlen), .arsize(arsize), .arburst(arburst),
      .rvalid(rvalid), .rready(rready), .rdata(rdata),
      .rresp(rresp), .rlast(rlast),
      .busy(rd_busy), .err(rd_err), .last_err(rlast_err),
      .mismatches(mismatch_cnt), .fin(rd_fin)
   );

   bw_cycle_timer #(.CYC_W(CYC_W)) u_wr_tmr (
      .clk(clk), .rst_n(rst_n), .clr(start_acc), .run(wr_busy), .count(wr_cycles)
   );

   bw_cycle_timer #(.CYC_W(CYC_W)) u_rd_tmr (
      .clk(clk), .rst_n(rst_n), .clr(start_acc), .run(rd_busy), .count(rd_cycles)
   );
endmodule

// File: rtl/axi_bw_probe_chk.sv
module axi_bw_probe_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 256,
   parameter int unsigned BEATS   = 128,
   parameter int unsigned MAX_OUT = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              awvalid,
   input logic              awready,
   input logic [ADDR_W-1:0] awaddr,
   input logic [7:0]        awlen,
   input logic              wvalid,
   input logic              wready,
   input logic [DATA_W-1:0] wdata,
   input logic              wlast,
   input logic              bvalid,
   input logic              bready,
   input logic              arvalid,
   input logic              arready,
   input logic [ADDR_W-1:0] araddr,
   input logic              rvalid,
   input logic              rready,
   input logic              done
);
   localparam int unsigned BURST_BYTES = BEATS * DATA_W / 8;
   localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(BURST_BYTES - 1);

   logic [31:0] aw_n, b_n, ar_n, rb_n, w_beat, r_beat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aw_n <= '0; b_n <= '0; ar_n <= '0; rb_n <= '0;
         w_beat <= '0; r_beat <= '0;
      end else begin
         if (awvalid && awready) aw_n <= aw_n + 1;
         if (bvalid && bready)   b_n  <= b_n + 1;
         if (arvalid && arready) ar_n <= ar_n + 1;
         if (wvalid && wready)
            w_beat <= (w_beat == BEATS - 1) ? '0 : w_beat + 1;
         if (rvalid && rready) begin
            if (r_beat == BEATS - 1) begin
               r_beat <= '0;
               rb_n   <= rb_n + 1;
            end else begin
               r_beat <= r_beat + 1;
            end
         end
      end
   end

   p_aw_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid |-> ((awaddr & PAGE_MASK) == '0) && (awlen == 8'(BEATS - 1)));

   p_wlast_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid |-> (wlast == (w_beat == BEATS - 1)));

   p_wr_inflight_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (aw_n - b_n) <= MAX_OUT);

   p_rd_inflight_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_n - rb_n) <= MAX_OUT);

   p_read_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid |-> (aw_n == b_n) && !wvalid && !awvalid);

   p_aw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid && !awready |=> awvalid && $stable(awaddr));

   p_w_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));

   p_ar_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid && !arready |=> arvalid && $stable(araddr));

   p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);
endmodule

bind axi_bw_probe axi_bw_probe_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS), .MAX_OUT(MAX_OUT)
) u_chk (.*);

// File: tb/axi_bw_probe_tb_top.sv
module axi_bw_probe_tb_top;
   localparam int ADDR_W = 32, DATA_W = 256, BURST_W = 17, BEATS = 128;
   localparam int MAX_OUT = 16, CYC_W = 32, CNT_W = 32;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [ADDR_W-1:0]  cfg_base = '0;
   logic [BURST_W-1:0] cfg_bursts = '0;
   logic awvalid, awready = 1'b0, wvalid, wready = 1'b0, wlast, bvalid = 1'b0, bready;
   logic arvalid, arready = 1'b0, rvalid = 1'b0, rready, rlast = 1'b0;
   logic [ADDR_W-1:0] awaddr, araddr;
   logic [7:0] awlen, arlen;
   logic [2:0] awsize, arsize;
   logic [1:0] awburst, arburst, bresp = 2'b00, rresp = 2'b00;
   logic [DATA_W-1:0] wdata, rdata = '0;
   logic [DATA_W/8-1:0] wstrb;
   logic done, wr_err, rd_err, rlast_err;
   logic [CYC_W-1:0] wr_cycles, rd_cycles;
   logic [CNT_W-1:0] mismatch_cnt;

   always #10 clk = ~clk;

   axi_bw_probe dut_i (.*);

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] pat(input logic [31:0] a);
      logic [DATA_W-1:0] d;
      for (int i = 0; i < DATA_W / 32; i++) d[32*i +: 32] = a + 32'(i);
      return d;
   endfunction

   // scoreboard queues and slave configuration
   logic [31:0] exp_aw_q[$], exp_ar_q[$];
   int corrupt_q[$];
   int b_lat, r_lat, rdy_pct, err_b, err_r, bad_last;
   int cur_n;
   logic [31:0] cur_base;
   int cyc = 0;
   int aw_hs, b_hs, ar_hs, r_bursts, w_beat_b, w_burst_b, r_beat_b;
   int max_w_out, max_r_out, wcyc_b, rcyc_b, order_viol, hold_viol, ready_low;
   bit in_w, in_r, w_started, r_started;
   int bdue_q[$], rdue_q[$], ridx_q[$];
   logic [1:0] bresp_q[$];
   logic [31:0] raddr_q[$];
   logic prev_aw_wait, prev_ar_wait;
   logic [31:0] prev_awaddr, prev_araddr;

   // slave model and monitor: runs away from the active edge
   initial begin
      prev_aw_wait = 0; prev_ar_wait = 0; prev_awaddr = 0; prev_araddr = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            if (!w_started && awvalid) begin w_started = 1; in_w = 1; end
            if (!r_started && arvalid) begin r_started = 1; in_r = 1; end
            if (in_w) wcyc_b++;
            if (in_r) rcyc_b++;
            if (!bready || !rready) ready_low++;
            if (prev_aw_wait && (!awvalid || awaddr != prev_awaddr)) hold_viol++;
            if (prev_ar_wait && (!arvalid || araddr != prev_araddr)) hold_viol++;
            if (arvalid && (b_hs != cur_n || aw_hs != cur_n)) order_viol++;
         end
         // AW channel
         begin
            logic rdy;
            rdy = ($urandom_range(99) < rdy_pct);
            if (awvalid && rdy) begin
               logic [31:0] e;
               e = (exp_aw_q.size() > 0) ? exp_aw_q.pop_front() : 32'hDEAD_BEEF;
               chk(awaddr == e && awlen == 8'd127 && awsize == 3'd5 && awburst == 2'b01,
                   "R1", "write address/attributes", awaddr, e);
               aw_hs++;
            end
            prev_aw_wait = awvalid && !rdy;
            prev_awaddr  = awaddr;
            awready = rdy;
         end
         // W channel
         begin
            logic rdy;
            rdy = ($urandom_range(99) < rdy_pct);
            if (wvalid && rdy) begin
               logic [31:0] a;
               logic exp_last;
               a = cur_base + 32'(w_burst_b) * 4096 + 32'(w_beat_b) * 32;
               exp_last = (w_beat_b == BEATS - 1);
               chk(wdata == pat(a) && wlast == exp_last && wstrb == '1,
                   "R2", "write beat", wdata[63:0], pat(a) >> 0 & 64'hFFFF_FFFF_FFFF_FFFF);
               if (exp_last) begin
                  w_beat_b = 0; w_burst_b++;
                  bdue_q.push_back(cyc + b_lat);
                  bresp_q.push_back((w_burst_b - 1 == err_b) ? 2'b10 : 2'b00);
               end else w_beat_b++;
            end
            wready = rdy;
         end
         if (aw_hs - b_hs > max_w_out) max_w_out = aw_hs - b_hs;
         // B channel
         if (bdue_q.size() > 0 && bdue_q[0] <= cyc) begin
            void'(bdue_q.pop_front());
            bresp  = bresp_q.pop_front();
            bvalid = 1'b1;
            b_hs++;
            if (b_hs == cur_n) in_w = 0;
         end else begin
            bvalid = 1'b0;
            bresp  = 2'b00;
         end
         // AR channel
         begin
            logic rdy;
            rdy = ($urandom_range(99) < rdy_pct);
            if (arvalid && rdy) begin
               logic [31:0] e;
               e = (exp_ar_q.size() > 0) ? exp_ar_q.pop_front() : 32'hDEAD_BEEF;
               chk(araddr == e && arlen == 8'd127 && arsize == 3'd5 && arburst == 2'b01,
                   "R4", "read address/attributes", araddr, e);
               raddr_q.push_back(araddr);
               rdue_q.push_back(cyc + r_lat);
               ridx_q.push_back(ar_hs);
               ar_hs++;
            end
            prev_ar_wait = arvalid && !rdy;
            prev_araddr  = araddr;
            arready = rdy;
         end
         if (ar_hs - r_bursts > max_r_out) max_r_out = ar_hs - r_bursts;
         // R channel
         if (raddr_q.size() > 0 && rdue_q[0] <= cyc && $urandom_range(99) < rdy_pct) begin
            int gidx;
            logic [DATA_W-1:0] d;
            gidx = ridx_q[0] * BEATS + r_beat_b;
            d = pat(raddr_q[0] + 32'(r_beat_b) * 32);
            foreach (corrupt_q[k]) if (corrupt_q[k] == gidx) d = d ^ 256'd1;
            rdata  = d;
            rresp  = (ridx_q[0] == err_r && r_beat_b == 0) ? 2'b10 : 2'b00;
            rlast  = (r_beat_b == BEATS - 1) || (ridx_q[0] == bad_last && r_beat_b == 50);
            rvalid = 1'b1;
            if (r_beat_b == BEATS - 1) begin
               r_beat_b = 0;
               void'(raddr_q.pop_front()); void'(rdue_q.pop_front()); void'(ridx_q.pop_front());
               r_bursts++;
               if (r_bursts == cur_n) in_r = 0;
            end else r_beat_b++;
         end else begin
            rvalid = 1'b0;
            rlast  = 1'b0;
            rresp  = 2'b00;
         end
      end
   end

   // driver: pushes expected addresses, starts a run, checks the results
   task automatic run_case(input logic [31:0] base, input int n, input int bl, input int rl,
                           input int pct, input int eb, input int er, input int erl,
                           input int restart_at, input bit expect_full_stall);
      int wait_cyc;
      @(negedge clk);
      cur_base = base; cur_n = n; b_lat = bl; r_lat = rl; rdy_pct = pct;
      err_b = eb; err_r = er; bad_last = erl;
      aw_hs = 0; b_hs = 0; ar_hs = 0; r_bursts = 0; w_beat_b = 0; w_burst_b = 0; r_beat_b = 0;
      max_w_out = 0; max_r_out = 0; wcyc_b = 0; rcyc_b = 0; order_viol = 0;
      hold_viol = 0; ready_low = 0;
      in_w = 0; in_r = 0; w_started = 0; r_started = 0;
      exp_aw_q.delete(); exp_ar_q.delete();
      for (int k = 0; k < n; k++) begin
         exp_aw_q.push_back(base + 32'(k) * 4096);
         exp_ar_q.push_back(base + 32'(k) * 4096);
      end
      cfg_base = base; cfg_bursts = BURST_W'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0 && wr_err == 1'b0 && rd_err == 1'b0 && rlast_err == 1'b0 &&
          mismatch_cnt == 0 && wr_cycles == 0 && rd_cycles == 0,
          "R12", "results cleared by start", {done, wr_err, rd_err, rlast_err}, 0);
      wait_cyc = 0;
      while (!done && wait_cyc < 60000) begin
         @(negedge clk);
         wait_cyc++;
         if (restart_at != 0 && wait_cyc == restart_at) start = 1'b1;
         else start = 1'b0;
      end
      start = 1'b0;
      chk(done == 1'b1, "R12", "done raised", done, 1);
      chk(aw_hs == n && exp_aw_q.size() == 0, "R1", "write burst count", aw_hs, n);
      chk(ar_hs == n && exp_ar_q.size() == 0, "R4", "read burst count", ar_hs, n);
      chk(order_viol == 0, "R4", "read issued before writes retired", order_viol, 0);
      chk(max_w_out <= MAX_OUT && max_r_out <= MAX_OUT, "R3", "in-flight limit",
          (max_w_out > max_r_out) ? max_w_out : max_r_out, MAX_OUT);
      if (expect_full_stall)
         chk(max_w_out == MAX_OUT && max_r_out == MAX_OUT, "R3", "stall reached limit",
             max_w_out * 100 + max_r_out, MAX_OUT * 101);
      chk(hold_viol == 0 && ready_low == 0, "R5", "valid hold / ready high",
          hold_viol + ready_low, 0);
      chk(wr_cycles == CYC_W'(wcyc_b), "R6", "write cycle count", wr_cycles, wcyc_b);
      chk(rd_cycles == CYC_W'(rcyc_b), "R7", "read cycle count", rd_cycles, rcyc_b);
      chk(wr_err == (eb >= 0), "R8", "write error flag", wr_err, eb >= 0);
      chk(rd_err == (er >= 0), "R9", "read error flag", rd_err, er >= 0);
      chk(mismatch_cnt == CNT_W'(corrupt_q.size()), "R10", "miscompare count",
          mismatch_cnt, corrupt_q.size());
      chk(rlast_err == (erl >= 0), "R11", "rlast error flag", rlast_err, erl >= 0);
      repeat (3) @(negedge clk);
      chk(done == 1'b1 && wr_err == (eb >= 0), "R12", "done and flags held", done, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rdy_pct = 100; cur_n = 0; cur_base = 0; b_lat = 1; r_lat = 1;
      err_b = -1; err_r = -1; bad_last = -1;
      repeat (4) @(negedge clk);
      chk(!awvalid && !wvalid && !arvalid && !done, "R13", "valids/done in reset",
          {awvalid, wvalid, arvalid, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wr_cycles == 0 && rd_cycles == 0 && mismatch_cnt == 0 &&
          !wr_err && !rd_err && !rlast_err, "R13", "results after reset", wr_cycles, 0);
      chk(!awvalid && !arvalid, "R13", "idle after reset", {awvalid, arvalid}, 0);

      // clean run, irregular ready
      corrupt_q.delete();
      run_case(32'h1000_0000, 20, 3, 2, 70, -1, -1, -1, 0, 1'b0);
      // slow responses force the in-flight limit to stall and resume
      run_case(32'h0004_0000, 40, 60, 60, 100, -1, -1, -1, 0, 1'b1);
      // fault injection: write error on burst 2, read error on burst 3,
      // early rlast in burst 1, two corrupted read beats
      corrupt_q.push_back(0 * BEATS + 5);
      corrupt_q.push_back(4 * BEATS + 127);
      run_case(32'h3FFF_0000, 6, 2, 4, 85, 2, 3, 1, 0, 1'b0);
      // start pulse while running is ignored; previous flags were cleared
      corrupt_q.delete();
      run_case(32'h0000_0000, 10, 5, 5, 90, -1, -1, -1, 40, 1'b0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule